// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a host bridge and rewrites request addresses through two programmable windows. Each window holds a transaction kind, an enable, a 64-bit base, a 32-bit inclusive upper bound and a 64-bit destination. A request whose address falls inside an enabled window leaves with its offset from the window base added to the destination. The window's kind goes with it, and a hit flag is raised. A request that matches no window leaves unchanged, with the hit flag low and the memory kind.

Software reaches the windows indirectly. A selector register names the direction and the window index. The remaining window registers then read and write the selected window. Software can retarget a window between configuration, I/O and memory kinds on the fly. A window used for configuration cycles carries a packed bus/device/function number in its destination. Requests enter and results leave on valid/ready streams with a single output register stage. A stalled output holds its beat and back-pressures the input.

Top module: `obx_outbound_xlate`

## Requirements
- R1: While reset is held, rsp_valid is 0, req_ready is 1, every window is disabled, and reg_rdata is 0 at every register offset.
- R2: The selector register sits at offset 0x900. Bit 31 holds the direction, 0 for outbound and 1 for inbound, and bit 0 holds the window index. A read returns only those two bits, with all other bits 0.
- R3: The selected window's registers sit at these offsets. Offset 0x904 holds the kind in bits 4:0, with memory 0, I/O 2, config type 0 as 4 and config type 1 as 5. Offset 0x908 holds the enable in bit 31, and its other bits read 0. Offset 0x90C is base low and 0x910 is base high. Offset 0x914 is the low 32 bits of the upper bound. Offset 0x918 is destination low and 0x91C is destination high. Reads return the window named by the selector.
- R4: While the selector's direction bit is 1, writes to offsets 0x904 to 0x91C change nothing, and reads of those offsets return 0.
- R5: A window hits when it is enabled and {base_hi, base_lo} ≤ address ≤ {base_hi, bound}. Both ends are inclusive, so one below the base and one above the bound both miss.
- R6: On a hit, rsp_addr = destination + (address − base), rsp_kind is the window's kind and rsp_hit is 1. For a configuration window, the destination low word carries bus in bits 31:24, device in bits 23:19 and function in bits 18:16.
- R7: On a miss, rsp_addr equals the request address, rsp_kind is 0 and rsp_hit is 0.
- R8: When both windows hit, window 0 supplies the result.
- R9: A request is taken when req_valid and req_ready are both 1, and req_ready = !rsp_valid || rsp_ready. The result is valid in the next cycle. While rsp_valid is 1 and rsp_ready is 0, the output beat stays unchanged.
- R10: A request taken in the same cycle as a register write is translated with the settings from before that write. A request taken in any later cycle sees the new settings.
- R11: Writes to offsets other than 0x900 to 0x91C are ignored, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request may be taken |
| req_addr | input | 64 | Untranslated request address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Downstream accepts the result |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_kind | output | 5 | Transaction kind of the result |
| rsp_hit | output | 1 | 1 when a window matched |

## Verification
A register write and the acceptance of a request can happen in the same cycle. Which settings the request sees is the main ordering hazard. The bench drives this case on purpose: it rewrites a window's kind and enable together with a request, then sends the same address in the next cycle. It also drives this case at random, mixing register writes with a stream of requests under random back-pressure. The reference model translates each request before applying the write from the same cycle. Every output beat and every read-back is compared against that model on each clock.

// File: rtl/obx_pkg.sv
package obx_pkg;

  localparam logic [11:0] OFS_VIEW = 12'h900;
  localparam logic [11:0] OFS_CR1  = 12'h904;
  localparam logic [11:0] OFS_CR2  = 12'h908;
  localparam logic [11:0] OFS_BLO  = 12'h90C;
  localparam logic [11:0] OFS_BHI  = 12'h910;
  localparam logic [11:0] OFS_LIM  = 12'h914;
  localparam logic [11:0] OFS_TLO  = 12'h918;
  localparam logic [11:0] OFS_THI  = 12'h91C;

  localparam logic [4:0] XK_MEM  = 5'd0;
  localparam logic [4:0] XK_IO   = 5'd2;
  localparam logic [4:0] XK_CFG0 = 5'd4;
  localparam logic [4:0] XK_CFG1 = 5'd5;

  typedef struct packed {
    logic        en;
    logic [4:0]  kind;
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] lim_lo;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } win_cfg_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [4:0]  kind;
    logic        hit;
  } xl_beat_t;

endpackage

// File: rtl/obx_regs.sv
module obx_regs
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [11:0]               addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg
);

  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic             vp_dir;
  logic [IDX_W-1:0] vp_idx;
  logic             sel_ok;
  win_cfg_t         win_q [NUM_WIN];
  win_cfg_t         cur;

  assign sel_ok = !vp_dir && (int'(vp_idx) < NUM_WIN);

  // selector register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
    end else if (wr_en && addr == OFS_VIEW) begin
      vp_dir <= wdata[31];
      vp_idx <= wdata[IDX_W-1:0];
    end
  end

  // per-window storage, written only through an outbound selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) win_q[i] <= '0;
    end else if (wr_en && sel_ok) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (vp_idx == IDX_W'(i)) begin
          case (addr)
            OFS_CR1: win_q[i].kind    <= wdata[4:0];
            OFS_CR2: win_q[i].en      <= wdata[31];
            OFS_BLO: win_q[i].base_lo <= wdata;
            OFS_BHI: win_q[i].base_hi <= wdata;
            OFS_LIM: win_q[i].lim_lo  <= wdata;
            OFS_TLO: win_q[i].tgt_lo  <= wdata;
            OFS_THI: win_q[i].tgt_hi  <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cfg_out
    assign cfg[g] = win_q[g];
  end

  assign cur = win_q[vp_idx];

  always_comb begin
    rdata = '0;
    if (addr == OFS_VIEW) begin
      rdata[31]        = vp_dir;
      rdata[IDX_W-1:0] = vp_idx;
    end else if (sel_ok) begin
      case (addr)
        OFS_CR1: rdata = {27'b0, cur.kind};
        OFS_CR2: rdata = {cur.en, 31'b0};
        OFS_BLO: rdata = cur.base_lo;
        OFS_BHI: rdata = cur.base_hi;
        OFS_LIM: rdata = cur.lim_lo;
        OFS_TLO: rdata = cur.tgt_lo;
        OFS_THI: rdata = cur.tgt_hi;
        default: rdata = '0;
      endcase
    end
  end

  AST_INBOUND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vp_dir && addr != OFS_VIEW) |=> $stable(cfg)) else $error("inbound write changed a window"); // R4

  AST_IDLE_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(cfg)) else $error("window changed without a write"); // R3

endmodule

// File: rtl/obx_match.sv
module obx_match
  import obx_pkg::*;
(
  input  win_cfg_t    cfg,
  input  logic [63:0] addr,
  output logic        hit,
  output logic [63:0] xaddr
);

  logic [63:0] base;
  logic [63:0] top;
  logic [63:0] dest;

  assign base  = {cfg.base_hi, cfg.base_lo};
  assign top   = {cfg.base_hi, cfg.lim_lo};
  assign dest  = {cfg.tgt_hi, cfg.tgt_lo};
  assign hit   = cfg.en && (addr >= base) && (addr <= top);
  assign xaddr = dest + (addr - base);

endmodule

// File: rtl/obx_ostage.sv
module obx_ostage
  import obx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  xl_beat_t in_beat,
  output logic     out_valid,
  input  logic     out_ready,
  output xl_beat_t out_beat
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_beat <= in_beat;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_beat))) else $error("beat moved while stalled"); // R9

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid) else $error("accepted beat lost"); // R9

endmodule

// File: rtl/obx_outbound_xlate.sv
module obx_outbound_xlate
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_addr,
  output logic [4:0]  rsp_kind,
  output logic        rsp_hit
);

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic     [NUM_WIN-1:0] win_hit;
  logic     [63:0]        win_xaddr [NUM_WIN];
  xl_beat_t               pick;
  xl_beat_t               beat_q;

  obx_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    obx_match u_match (
      .cfg   (cfg[g]),
      .addr  (req_addr),
      .hit   (win_hit[g]),
      .xaddr (win_xaddr[g])
    );
  end

  // lowest window index wins
  always_comb begin
    pick.addr = req_addr;
    pick.kind = XK_MEM;
    pick.hit  = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        pick.addr = win_xaddr[i];
        pick.kind = cfg[i].kind;
        pick.hit  = 1'b1;
      end
    end
  end

  obx_ostage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_beat   (pick),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_beat  (beat_q)
  );

  assign rsp_addr = beat_q.addr;
  assign rsp_kind = beat_q.kind;
  assign rsp_hit  = beat_q.hit;

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit == '0) |=>
      (rsp_addr == $past(req_addr) && !rsp_hit && rsp_kind == XK_MEM)) else $error("miss altered"); // R7

  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_hit == $past(|win_hit))) else $error("hit flag wrong"); // R5

  AST_WIN0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit[0]) |=>
      (rsp_addr == $past(win_xaddr[0]) && rsp_kind == $past(cfg[0].kind))) else $error("priority"); // R8

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid) |-> req_ready) else $error("ready low with empty stage"); // R9

endmodule

// File: tb/tb_obx_outbound_xlate.sv
`timescale 1ns/1ps
module tb_obx_outbound_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [63:0] rsp_addr;
  logic [4:0]  rsp_kind;
  logic        rsp_hit;

  always #2.5 clk = ~clk;

  obx_outbound_xlate dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rsp_hit(rsp_hit)
  );

  int compared = 0;
  int mismatched = 0;
  bit running = 0;

  // reference model state
  bit          m_dir;
  bit          m_idx;
  bit          m_en   [2];
  logic [4:0]  m_kind [2];
  logic [31:0] m_blo  [2];
  logic [31:0] m_bhi  [2];
  logic [31:0] m_lim  [2];
  logic [31:0] m_tlo  [2];
  logic [31:0] m_thi  [2];
  bit          mv;
  logic [63:0] ma;
  logic [4:0]  mk;
  bit          mh;
  string       mtag;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(logic [11:0] a);
    int i;
    i = int'(m_idx);
    if (a == 12'h900) return {m_dir, 30'b0, m_idx};
    if (m_dir) return 32'h0;
    case (a)
      12'h904: return {27'b0, m_kind[i]};
      12'h908: return {m_en[i], 31'b0};
      12'h90C: return m_blo[i];
      12'h910: return m_bhi[i];
      12'h914: return m_lim[i];
      12'h918: return m_tlo[i];
      12'h91C: return m_thi[i];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [11:0] a);
    if (a == 12'h900) return "R2";
    if (a < 12'h900 || a > 12'h91C || a[1:0] != 2'b00) return "R11";
    if (m_dir) return "R4";
    return "R3";
  endfunction

  always @(posedge clk) begin : model
    bit          acc;
    int          sel;
    int          nhit;
    bit          edge_addr;
    logic [63:0] b;
    logic [63:0] t;
    if (!rst_n) begin
      m_dir = 0; m_idx = 0; mv = 0; ma = '0; mk = '0; mh = 0; mtag = "R1";
      for (int i = 0; i < 2; i++) begin
        m_en[i] = 0; m_kind[i] = '0; m_blo[i] = '0; m_bhi[i] = '0;
        m_lim[i] = '0; m_tlo[i] = '0; m_thi[i] = '0;
      end
    end else begin
      acc = req_valid && (!mv || rsp_ready);
      if (mv && rsp_ready) mv = 0;
      if (acc) begin
        sel = -1; nhit = 0; edge_addr = 0;
        for (int i = 0; i < 2; i++) begin
          b = {m_bhi[i], m_blo[i]};
          t = {m_bhi[i], m_lim[i]};
          if (m_en[i] && (req_addr == b || req_addr == t || req_addr == b - 1 || req_addr == t + 1))
            edge_addr = 1;
          if (m_en[i] && req_addr >= b && req_addr <= t) begin
            nhit++;
            if (sel < 0) sel = i;
          end
        end
        mv = 1;
        if (sel >= 0) begin
          ma = {m_thi[sel], m_tlo[sel]} + (req_addr - {m_bhi[sel], m_blo[sel]});
          mk = m_kind[sel];
          mh = 1;
        end else begin
          ma = req_addr; mk = 5'd0; mh = 0;
        end
        if (reg_we) mtag = "R10";
        else if (nhit == 2) mtag = "R8";
        else if (edge_addr) mtag = "R5";
        else if (sel >= 0) mtag = "R6";
        else mtag = "R7";
      end
      if (reg_we) begin
        if (reg_addr == 12'h900) begin
          m_dir = reg_wdata[31];
          m_idx = reg_wdata[0];
        end else if (!m_dir) begin
          case (reg_addr)
            12'h904: m_kind[int'(m_idx)] = reg_wdata[4:0];
            12'h908: m_en[int'(m_idx)]   = reg_wdata[31];
            12'h90C: m_blo[int'(m_idx)]  = reg_wdata;
            12'h910: m_bhi[int'(m_idx)]  = reg_wdata;
            12'h914: m_lim[int'(m_idx)]  = reg_wdata;
            12'h918: m_tlo[int'(m_idx)]  = reg_wdata;
            12'h91C: m_thi[int'(m_idx)]  = reg_wdata;
            default: ;
          endcase
        end
      end
    end
    #1;
    if (running && rst_n) begin
      chk("R9", "req_ready", 64'(req_ready), 64'(!mv || rsp_ready));
      chk("R9", "rsp_valid", 64'(rsp_valid), 64'(mv));
      if (mv) begin
        chk(mtag, "rsp_addr", rsp_addr, ma);
        chk(mtag, "rsp_kind", 64'(rsp_kind), 64'(mk));
        chk(mtag, "rsp_hit", 64'(rsp_hit), 64'(mh));
      end
      chk(rd_tag(reg_addr), "reg_rdata", 64'(reg_rdata), 64'(mdl_read(reg_addr)));
    end
  end

  task automatic step(bit we, logic [11:0] a, logic [31:0] d, bit rv, logic [63:0] ra, bit ordy);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    req_valid = rv; req_addr = ra; rsp_ready = ordy;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(1, a, d, 0, 64'h0, 1);
  endtask

  task automatic rd(logic [11:0] a);
    step(0, a, 32'h0, 0, 64'h0, 1);
  endtask

  task automatic send(logic [63:0] ra);
    step(0, 12'h900, 32'h0, 1, ra, 1);
  endtask

  task automatic prog(bit idx, logic [4:0] k, bit en, logic [31:0] blo, logic [31:0] bhi,
                      logic [31:0] lim, logic [31:0] tlo, logic [31:0] thi);
    wr(12'h900, {31'b0, idx});
    wr(12'h904, {27'b0, k});
    wr(12'h90C, blo);
    wr(12'h910, bhi);
    wr(12'h914, lim);
    wr(12'h918, tlo);
    wr(12'h91C, thi);
    wr(12'h908, {en, 31'b0});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [11:0] offs [8];
    offs = '{12'h900, 12'h904, 12'h908, 12'h90C, 12'h910, 12'h914, 12'h918, 12'h91C};
    rst_n = 0; reg_we = 0; reg_addr = 12'h900; reg_wdata = 0;
    req_valid = 0; req_addr = 0; rsp_ready = 1;
    repeat (2) @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R1", "req_ready", 64'(req_ready), 64'h1);
    foreach (offs[i]) begin
      @(negedge clk);
      reg_addr = offs[i];
      #1 chk("R1", "reg_rdata", 64'(reg_rdata), 64'h0);
    end
    @(negedge clk);
    rst_n = 1;
    running = 1;

    // R3 programming; window 1 is a config window with bus 1, dev 3, fn 2 (R6)
    prog(0, 5'd0, 1, 32'h4000_0000, 32'h1, 32'h4000_FFFF, 32'h8000_0000, 32'h2);
    prog(1, 5'd4, 1, 32'h4000_8000, 32'h1, 32'h4001_7FFF, 32'h011A_0000, 32'h0);
    foreach (offs[i]) rd(offs[i]);
    wr(12'h900, 32'h0);
    foreach (offs[i]) rd(offs[i]);

    // R5 boundaries, R6 translation, R7 miss, R8 overlap
    send(64'h1_4000_0000);
    send(64'h1_4000_FFFF);
    send(64'h1_4000_9000);
    send(64'h1_4001_0000);
    send(64'h1_4001_7FFF);
    send(64'h1_4001_8000);
    send(64'h1_3FFF_FFFF);
    send(64'h0_4000_0000);

    // R2 selector keeps only bits 31 and 0
    wr(12'h900, 32'h7FFF_FFFE);
    rd(12'h900);
    // R4 inbound selection blocks writes and reads zero
    wr(12'h900, 32'h8000_0001);
    wr(12'h90C, 32'hDEAD_BEEF);
    wr(12'h908, 32'h0);
    rd(12'h90C);
    rd(12'h908);
    wr(12'h900, 32'h1);
    rd(12'h90C);
    rd(12'h908);
    // R11 unmapped offsets
    wr(12'h920, 32'hFFFF_FFFF);
    rd(12'h920);
    wr(12'h8FC, 32'h1234_5678);
    rd(12'h8FC);

    // R10 write and request in the same cycle, then the next request
    wr(12'h900, 32'h0);
    step(1, 12'h904, 32'h2, 1, 64'h1_4000_0010, 1);
    send(64'h1_4000_0010);
    step(1, 12'h908, 32'h0, 1, 64'h1_4000_0010, 1);
    send(64'h1_4000_0010);
    wr(12'h908, 32'h8000_0000);

    // R9 back-pressure
    step(0, 12'h900, 0, 1, 64'h1_4000_0100, 0);
    step(0, 12'h900, 0, 1, 64'h1_4000_0200, 0);
    step(0, 12'h900, 0, 1, 64'h1_4000_0300, 0);
    step(0, 12'h900, 0, 1, 64'h1_4000_0300, 1);
    step(0, 12'h900, 0, 0, 64'h0, 1);

    // mixed random traffic with reprogramming
    for (int n = 0; n < 4000; n++) begin
      bit          we;
      logic [11:0] a;
      logic [31:0] d;
      logic [63:0] ra;
      int          w;
      we = ($urandom % 8) == 0;
      a  = offs[$urandom % 8];
      case (a)
        12'h900: d = {($urandom % 10) == 0, 30'b0, 1'($urandom)};
        12'h904: begin
          w = $urandom % 4;
          d = (w == 0) ? 32'd0 : (w == 1) ? 32'd2 : (w == 2) ? 32'd4 : 32'd5;
        end
        12'h908: d = {($urandom % 4) != 0, 31'($urandom)};
        12'h90C: d = 32'h4000_0000 + ($urandom % 4) * 32'h8000;
        12'h910: d = (($urandom % 8) == 0) ? 32'h0 : 32'h1;
        12'h914: d = 32'h4000_0000 + ($urandom % 8) * 32'h4000 + 32'h3FFF;
        default: d = $urandom;
      endcase
      w = $urandom % 4;
      if (w == 0)
        ra = {m_bhi[$urandom % 2], m_blo[$urandom % 2]} + 64'(($urandom % 3)) - 64'h1;
      else if (w == 1)
        ra = {m_bhi[$urandom % 2], m_lim[$urandom % 2]} + 64'(($urandom % 3)) - 64'h1;
      else if (w == 2)
        ra = {32'h1, 32'h4000_0000 + ($urandom % 32'h20000)};
      else
        ra = {32'($urandom % 3), 32'($urandom)};
      step(we, a, d, ($urandom % 4) != 0, ra, ($urandom % 4) != 0);
    end
    step(0, 12'h900, 0, 0, 64'h0, 1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule